// File: doc/BRIEF.md
# Dual-Supply Reset Sequencer

This controller produces two active-low reset lines, one per monitored supply rail. Each rail reaches it as a single in-tolerance bit from an external comparator. A reset asserts when its rail drops out of tolerance. It stays asserted until the rail has been good for a selectable hold time. All timing counts a free-running microsecond tick enable, so the same logic serves any system clock.

Each rail has its own manual reset button. A master button forces both resets and the interrupt-force output together. Button presses are only accepted after a minimum low time, and each output is held for its own delay after the button is released. Short dips of a rail's good bit are filtered out. A "monitoring valid" bit holds every output active while the comparators cannot be trusted. A status flag records whether the latest reset came from the master button.

Each rail has a two-bit delay code that selects a short, medium or long hold time. The code is sampled once, on the first clock after power-on reset, and is then frozen until the next power-on reset.

Top module: `dual_reset_seq`

## Requirements
- R1: Once a rail's synchronized good bit has been low for at least GLITCH_US ticks, that rail's reset output goes low and stays low while the bit remains low.
- R2: After the good bit returns high, the reset stays low for the selected hold time and then rises. During that time the other rail's reset is not affected.
- R3: The delay code maps as follows: 2'b00 selects DLY_LO_US, 2'b01 selects DLY_MID_US, 2'b10 selects DLY_HI_US, and 2'b11 is treated like 2'b01.
- R4: Both delay codes are captured on the first clock after power-on reset. Later changes to them have no effect until the next power-on reset.
- R5: After power-on reset both resets are low. Each reset rises only after its rail has first become good and the full selected hold time has passed.
- R6: A rail's button that is held low for at least PB_QUAL_US ticks drives that rail's reset low. The reset stays low while the button is held and for one hold time after release. A shorter press has no effect, and the other rail is never affected.
- R7: A low on a rail's good bit that lasts fewer than GLITCH_US ticks never asserts a reset.
- R8: A master button press held for at least PB_QUAL_US ticks drives both resets and nmiForceN low. After release, nmiForceN rises after NMI_HOLD_US ticks, and each reset rises after its own hold time.
- R9: A master press is ignored while neither rail's good bit is high. In that case nmiForceN and lastCauseN are unchanged.
- R10: While monValid is low, rstAN, rstBN and nmiForceN are all held low. When monValid rises, each output goes through its normal release timing.
- R11: lastCauseN is high after power-on reset. It goes low when a master press is accepted. It returns high only when a rail fault or a rail button qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| tickUs | input | 1 | One-cycle pulse each microsecond, used as the time base |
| supOkA | input | 1 | Rail A in-tolerance bit (asynchronous) |
| supOkB | input | 1 | Rail B in-tolerance bit (asynchronous) |
| pbAN | input | 1 | Rail A manual reset button, active low (asynchronous) |
| pbBN | input | 1 | Rail B manual reset button, active low (asynchronous) |
| masterPbN | input | 1 | Master manual reset button, active low (asynchronous) |
| monValid | input | 1 | High when rail sensing is accurate (asynchronous) |
| dlySelA | input | 2 | Rail A hold-time code, sampled once after power-on |
| dlySelB | input | 2 | Rail B hold-time code, sampled once after power-on |
| rstAN | output | 1 | Rail A reset, active low |
| rstBN | output | 1 | Rail B reset, active low |
| nmiForceN | output | 1 | Interrupt-channel force, active low |
| lastCauseN | output | 1 | Low when the latest reset came from the master button |

## Verification
The assertions assume that tickUs is a single-cycle pulse and that every input is held for at least a few cycles. They also assume the delay codes do not change during the first clock after power-on reset.

The bench drives tickUs high on every cycle, so microseconds and cycles are the same. It changes inputs only on falling clock edges. Random glitch widths are drawn well below the glitch window, and random press lengths well above or below the qualification window. Release times are checked against a small window that covers the synchronizer and filter latency.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic [1:0] chanHold;  // keep the rail reset asserted and reload its delay
    logic       nmiHold;   // keep the interrupt force asserted
    logic       selLoad;   // capture the delay codes (first cycle after power-on)
  } rsq_strobe_t;
endpackage

// File: rtl/rsq_lowfilt.sv
module rsq_lowfilt #(
  parameter int LIMIT = 20,
  parameter bit RST_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic lvlLow,
  output logic qual
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  // Count ticks while the level stays low; clear as soon as it goes high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= RST_QUAL ? LIM : '0;
    else if (!lvlLow) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign qual = (cnt == LIM);

  // R7 / R6: a qualification can only begin while the level is low.
  p_qual_needs_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qual) |-> $past(lvlLow));
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
#(
  parameter int GLITCH_US  = 2,
  parameter int PB_QUAL_US = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [1:0]  supOk,
  input  logic [1:0]  pbN,
  input  logic        masterPbN,
  input  logic        monValid,
  output rsq_strobe_t strobe,
  output logic        lastCauseN
);
  localparam int NS = 6;
  localparam logic [NS-1:0] SYNC_RST = 6'b0_1_11_00;

  logic [NS-1:0] raw, s1, s2;
  assign raw = {monValid, masterPbN, pbN, supOk};

  // Two-flop synchronizer for every asynchronous input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  logic [1:0] okS, pbS;
  logic       mpS, mvS;
  assign okS = s2[1:0];
  assign pbS = s2[3:2];
  assign mpS = s2[4];
  assign mvS = s2[5];

  logic [1:0] faultQ, pbQ;
  logic       masterQ;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    rsq_lowfilt #(.LIMIT(GLITCH_US), .RST_QUAL(1'b1)) u_supFilt (
      .clk(clk), .rstN(rstN), .tick(tick), .lvlLow(!okS[g]), .qual(faultQ[g]));
    rsq_lowfilt #(.LIMIT(PB_QUAL_US), .RST_QUAL(1'b0)) u_pbFilt (
      .clk(clk), .rstN(rstN), .tick(tick), .lvlLow(!pbS[g]), .qual(pbQ[g]));
  end

  rsq_lowfilt #(.LIMIT(PB_QUAL_US), .RST_QUAL(1'b0)) u_masterFilt (
    .clk(clk), .rstN(rstN), .tick(tick), .lvlLow(!mpS), .qual(masterQ));

  logic anyOk;
  assign anyOk = |okS;

  logic masterAcc, masterPrev, started;
  logic [1:0] faultPrev, pbPrev;

  // Master acceptance is gated by at least one good rail; it lasts while the button is held.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) masterAcc <= 1'b0;
    else if (!masterQ) masterAcc <= 1'b0;
    else if (anyOk) masterAcc <= 1'b1;
  end

  logic masterRise, otherRise;
  assign masterRise = masterAcc & ~masterPrev;
  assign otherRise  = (|(faultQ & ~faultPrev)) | (|(pbQ & ~pbPrev));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterPrev <= 1'b0;
      faultPrev  <= 2'b11;
      pbPrev     <= 2'b00;
      started    <= 1'b0;
      lastCauseN <= 1'b1;
    end else begin
      masterPrev <= masterAcc;
      faultPrev  <= faultQ;
      pbPrev     <= pbQ;
      started    <= 1'b1;
      if (masterRise) lastCauseN <= 1'b0;
      else if (otherRise) lastCauseN <= 1'b1;
    end
  end

  always_comb begin
    strobe.chanHold = faultQ | pbQ | {2{masterAcc | ~mvS}};
    strobe.nmiHold  = masterAcc | ~mvS;
    strobe.selLoad  = ~started;
  end

  // R9: a master press is only accepted while some rail is good.
  p_master_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterAcc) |-> $past(anyOk));
  // R11: an accepted master press marks the status flag.
  p_status_master_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterAcc) |=> !lastCauseN);
endmodule

// File: rtl/rsq_dpath.sv
module rsq_dpath
  import rsq_pkg::*;
#(
  parameter int DLY_LO_US   = 16000,
  parameter int DLY_MID_US  = 160000,
  parameter int DLY_HI_US   = 1600000,
  parameter int NMI_HOLD_US = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  rsq_strobe_t strobe,
  input  logic [1:0]  selA,
  input  logic [1:0]  selB,
  output logic [1:0]  chanRstN,
  output logic        nmiForceN
);
  localparam int CW = $clog2(DLY_HI_US + 1);
  localparam int NW = $clog2(NMI_HOLD_US + 1);

  logic [1:0] selReg [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg[0] <= 2'b01;
      selReg[1] <= 2'b01;
    end else if (strobe.selLoad) begin
      selReg[0] <= selA;
      selReg[1] <= selB;
    end
  end

  function automatic logic [CW-1:0] mapDly(input logic [1:0] code);
    case (code)
      2'b00:   return CW'(DLY_LO_US);
      2'b10:   return CW'(DLY_HI_US);
      default: return CW'(DLY_MID_US);
    endcase
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic          active;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (strobe.chanHold[g]) begin
        active <= 1'b1;
        cnt    <= mapDly(selReg[g]);
      end else if (active && tick) begin
        if (cnt <= CW'(1)) active <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
    end

    assign chanRstN[g] = ~active;

    // R1: a hold request asserts the reset on the next edge.
    p_hold_asserts_r1: assert property (@(posedge clk) disable iff (!rstN)
      strobe.chanHold[g] |=> !chanRstN[g]);
    // R2: release only on a tick with no hold pending.
    p_no_early_release_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanRstN[g]) |-> ($past(tick) && !$past(strobe.chanHold[g])));
  end

  logic          nmiAct;
  logic [NW-1:0] nmiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiAct <= 1'b1;
      nmiCnt <= NW'(NMI_HOLD_US);
    end else if (strobe.nmiHold) begin
      nmiAct <= 1'b1;
      nmiCnt <= NW'(NMI_HOLD_US);
    end else if (nmiAct && tick) begin
      if (nmiCnt <= NW'(1)) nmiAct <= 1'b0;
      else nmiCnt <= nmiCnt - 1'b1;
    end
  end

  assign nmiForceN = ~nmiAct;

  // R4: the captured codes never move after the load cycle.
  p_sel_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.selLoad |=> ($stable(selReg[0]) && $stable(selReg[1])));
  // R8 / R10: an interrupt hold request forces the output low.
  p_nmi_forced_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nmiHold |=> !nmiForceN);
endmodule

// File: rtl/dual_reset_seq.sv
module dual_reset_seq
  import rsq_pkg::*;
#(
  parameter int GLITCH_US   = 2,
  parameter int PB_QUAL_US  = 20,
  parameter int NMI_HOLD_US = 20,
  parameter int DLY_LO_US   = 16000,
  parameter int DLY_MID_US  = 160000,
  parameter int DLY_HI_US   = 1600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       supOkA,
  input  logic       supOkB,
  input  logic       pbAN,
  input  logic       pbBN,
  input  logic       masterPbN,
  input  logic       monValid,
  input  logic [1:0] dlySelA,
  input  logic [1:0] dlySelB,
  output logic       rstAN,
  output logic       rstBN,
  output logic       nmiForceN,
  output logic       lastCauseN
);
  rsq_strobe_t strobe;
  logic [1:0]  chanRstN;

  rsq_ctrl #(.GLITCH_US(GLITCH_US), .PB_QUAL_US(PB_QUAL_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tickUs),
    .supOk({supOkB, supOkA}), .pbN({pbBN, pbAN}),
    .masterPbN(masterPbN), .monValid(monValid),
    .strobe(strobe), .lastCauseN(lastCauseN));

  rsq_dpath #(.DLY_LO_US(DLY_LO_US), .DLY_MID_US(DLY_MID_US),
              .DLY_HI_US(DLY_HI_US), .NMI_HOLD_US(NMI_HOLD_US)) u_dpath (
    .clk(clk), .rstN(rstN), .tick(tickUs), .strobe(strobe),
    .selA(dlySelA), .selB(dlySelB),
    .chanRstN(chanRstN), .nmiForceN(nmiForceN));

  assign rstAN = chanRstN[0];
  assign rstBN = chanRstN[1];
endmodule

// File: tb/dual_reset_seq_tb_top.sv
`timescale 1ns/1ps
module dual_reset_seq_tb_top;
  localparam int GL = 4, PQ = 20, NH = 30, DLO = 60, DMID = 150, DHI = 400;
  localparam int SLACK = 8;

  logic clk = 1'b0, rstN = 1'b0, tickUs = 1'b1;
  logic supOkA = 0, supOkB = 0, pbAN = 1, pbBN = 1, masterPbN = 1, monValid = 0;
  logic [1:0] dlySelA = 2'b00, dlySelB = 2'b10;
  logic rstAN, rstBN, nmiForceN, lastCauseN;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_reset_seq #(.GLITCH_US(GL), .PB_QUAL_US(PQ), .NMI_HOLD_US(NH),
    .DLY_LO_US(DLO), .DLY_MID_US(DMID), .DLY_HI_US(DHI)) dut_i (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .supOkA(supOkA), .supOkB(supOkB),
    .pbAN(pbAN), .pbBN(pbBN), .masterPbN(masterPbN), .monValid(monValid),
    .dlySelA(dlySelA), .dlySelB(dlySelB), .rstAN(rstAN), .rstBN(rstBN),
    .nmiForceN(nmiForceN), .lastCauseN(lastCauseN));

  function automatic int dlyOf(logic [1:0] code);
    case (code)
      2'b00:   return DLO;
      2'b10:   return DHI;
      default: return DMID;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic inWin(string req, int t, int exp);
    check(t >= exp && t <= exp + SLACK, req, t, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watch outputs for n cycles: first cycle each is high, and whether each was ever low.
  task automatic watch(int n, output int tA, output int tB, output int tN,
                       output bit lowA, output bit lowB, output bit lowN);
    tA = -1; tB = -1; tN = -1; lowA = 0; lowB = 0; lowN = 0;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (rstAN && tA < 0) tA = c;
      if (rstBN && tB < 0) tB = c;
      if (nmiForceN && tN < 0) tN = c;
      if (!rstAN) lowA = 1;
      if (!rstBN) lowB = 1;
      if (!nmiForceN) lowN = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int tA, tB, tN, len, seedDummy;
    bit lA, lB, lN;
    seedDummy = $urandom(32'd20240611);

    // Reset state
    idle(3);
    check(!rstAN && !rstBN, "R5 reset state", {rstAN, rstBN}, 0);
    check(!nmiForceN, "R10 reset state nmi", nmiForceN, 0);
    check(lastCauseN, "R11 reset state flag", lastCauseN, 1);

    @(negedge clk); rstN = 1;
    idle(3);
    dlySelA = 2'b10;  // must be ignored (R4)
    dlySelB = 2'b00;
    idle(5);
    check(!rstAN && !nmiForceN, "R10 monValid low holds", {rstAN, nmiForceN}, 0);

    // monValid rises while rails are still bad
    monValid = 1;
    watch(NH + 20, tA, tB, tN, lA, lB, lN);
    inWin("R10 nmi release", tN, NH);
    check(tA < 0 && tB < 0, "R1 resets stay low while rails bad", tA, -1);

    // Rails come good: full delays from the captured codes (00 and 10)
    supOkA = 1; supOkB = 1;
    watch(DHI + 20, tA, tB, tN, lA, lB, lN);
    inWin("R4 R5 rail A power-up delay", tA, dlyOf(2'b00));
    inWin("R3 R5 rail B power-up delay", tB, dlyOf(2'b10));
    check(lastCauseN, "R11 flag high after power-up", lastCauseN, 1);

    // Short glitches on rail A are filtered
    for (int k = 0; k < 6; k++) begin
      len = 1 + ($urandom % (GL - 2));
      supOkA = 0; idle(len); supOkA = 1;
      watch(12, tA, tB, tN, lA, lB, lN);
      check(!lA, "R7 glitch ignored", len, 0);
    end

    // Long fault on rail A
    len = GL + 10 + ($urandom % 20);
    supOkA = 0;
    idle(len);
    check(!rstAN, "R1 fault asserts reset", rstAN, 0);
    supOkA = 1;
    watch(DLO + 20, tA, tB, tN, lA, lB, lN);
    inWin("R2 rail A release delay", tA, DLO);
    check(!lB, "R2 rail B untouched", lB, 0);

    // Rail B button: long press, random length
    len = PQ + 5 + ($urandom % 30);
    pbBN = 0; idle(len);
    check(!rstBN && rstAN, "R6 button B asserts only B", {rstAN, rstBN}, 2);
    pbBN = 1;
    watch(DHI + 20, tA, tB, tN, lA, lB, lN);
    inWin("R6 button B release delay", tB, DHI);
    check(!lA, "R6 rail A untouched", lA, 0);

    // Short presses ignored
    for (int k = 0; k < 4; k++) begin
      len = 1 + ($urandom % (PQ - 4));
      pbAN = 0; idle(len); pbAN = 1;
      watch(10, tA, tB, tN, lA, lB, lN);
      check(!lA, "R6 short press ignored", len, 0);
    end

    // Master press
    len = PQ + 10 + ($urandom % 20);
    masterPbN = 0; idle(len);
    check(!rstAN && !rstBN && !nmiForceN, "R8 master forces all",
          {rstAN, rstBN, nmiForceN}, 0);
    check(!lastCauseN, "R11 master marks flag", lastCauseN, 0);
    masterPbN = 1;
    watch(DHI + 20, tA, tB, tN, lA, lB, lN);
    inWin("R8 nmi release", tN, NH);
    inWin("R8 rail A release", tA, DLO);
    inWin("R8 rail B release", tB, DHI);
    check(!lastCauseN, "R11 flag holds after release", lastCauseN, 0);

    // Another source clears the flag
    pbAN = 0; idle(PQ + 10); pbAN = 1;
    idle(3);
    check(lastCauseN, "R11 button clears flag", lastCauseN, 1);
    idle(DLO + 20);

    // Master ignored with both rails bad
    supOkA = 0; supOkB = 0;
    idle(20);
    masterPbN = 0;
    watch(PQ + 20, tA, tB, tN, lA, lB, lN);
    check(!lN, "R9 nmi untouched", lN, 0);
    check(lastCauseN, "R9 flag untouched", lastCauseN, 1);
    masterPbN = 1;
    idle(5);
    supOkA = 1; supOkB = 1;
    idle(DHI + 20);

    // monValid drop mid-operation
    monValid = 0; idle(6);
    check(!rstAN && !rstBN && !nmiForceN, "R10 all held", {rstAN, rstBN, nmiForceN}, 0);
    monValid = 1;
    watch(DHI + 20, tA, tB, tN, lA, lB, lN);
    inWin("R10 rail A after monValid", tA, DLO);
    inWin("R10 nmi after monValid", tN, NH);

    // Second power cycle: codes 01 and 11 both map to the medium delay
    @(negedge clk); rstN = 0;
    dlySelA = 2'b01; dlySelB = 2'b11;
    supOkA = 0; supOkB = 0;
    idle(3);
    @(negedge clk); rstN = 1;
    idle(4);
    supOkA = 1; supOkB = 1;
    watch(DMID + 20, tA, tB, tN, lA, lB, lN);
    inWin("R3 code 01", tA, dlyOf(2'b01));
    inWin("R3 code 11", tB, dlyOf(2'b11));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule